// File: doc/BRIEF.md
# Serial EEPROM Device Model (64 x 16, three-wire command port)

This block behaves like a small serial EEPROM of 64 sixteen-bit words, reached through a chip select, a serial clock, a data input and a data output. A command is framed by chip select. It starts with a 1 bit, followed by a two-bit opcode and a six-bit address sent MSB first. Some commands then take sixteen data bits, and a read sends sixteen bits back. The pins are oversampled by the system clock. They pass through a short synchronizer, and a rising serial clock edge is detected in the system clock domain. Every internal step therefore runs on `clk`.

Seven instructions are decoded. Opcode 10 reads a word, 01 writes a word and 11 erases a word. Opcode 00 is an extended instruction, chosen by the top two address bits: 11 unlocks programming, 00 locks it, 10 erases every word and 01 writes one value to every word. All programming acts in a single internal cycle, and only while the write-enable latch is set. The controller's states are IDLE, OPCODE, ADDRESS, DATA_IN, READ_OUT and HOLD. The transitions are:
- IDLE goes to OPCODE on a 1 bit.
- OPCODE goes to ADDRESS after two bits.
- ADDRESS goes to READ_OUT (read), to DATA_IN (write, fill-all) or to HOLD (erase, erase-all, lock, unlock).
- DATA_IN goes to HOLD after sixteen bits.
- READ_OUT goes to HOLD after the last bit.
- Any state returns to IDLE when chip select falls.

Top module: `ser_eeprom`

## Requirements
- R1: After reset, dout is 0, the controller is in IDLE and the write-enable latch is clear.
- R2: While chip select is high in IDLE, 0 bits are ignored; the first 1 bit sampled on a rising serial clock edge starts a command.
- R3: Opcode 10 with a 6-bit address answers with one 0 bit right after the last address edge, then the 16 word bits MSB first, one new bit per rising serial clock edge.
- R4: Opcode 01 with an address and 16 data bits (MSB first) stores the data in that word when writing is enabled.
- R5: Opcode 11 with an address sets that word to 16'hFFFF when writing is enabled.
- R6: Opcode 00 with address bits [5:4]=11 sets the write-enable latch, and with [5:4]=00 clears it; address bits [3:0] are don't-care.
- R7: Opcode 00 with [5:4]=10 sets every word to 16'hFFFF, and with [5:4]=01 followed by 16 data bits writes that value to every word, both only when writing is enabled.
- R8: With the write-enable latch clear, write, erase, erase-all and fill-all leave every word unchanged.
- R9: Chip select low aborts any command: the controller returns to IDLE, dout goes to 0, and no program happens on a clock edge sampled together with chip select low.
- R10: dout is 0 except while read data is being shifted; after the last read bit, the next rising edge returns it to 0.
- R11: Reset sets every word to 16'hFFFF.
- R12: Bits clocked after a command is complete are ignored until chip select falls.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the serial pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs | input | 1 | Chip select, high frames a command |
| sclk | input | 1 | Serial clock; input bits are taken on its rising edge |
| din | input | 1 | Serial command, address and data input |
| dout | output | 1 | Serial read data; 0 when not shifting |

## Verification
The clash that matters is a falling chip select that reaches the controller in the same system cycle as the rising serial clock edge carrying the final data bit of a write. The bench provokes it by changing the last data bit, raising sclk and dropping cs at one instant. The synchronizer then delivers the edge and the deselect together. The bench judges it by reading the word back: the earlier value must still be there, because deselect takes priority over programming.

// File: rtl/ser_eeprom_pkg.sv
package ser_eeprom_pkg;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_OPC  = 3'd1,
        ST_ADR  = 3'd2,
        ST_DIN  = 3'd3,
        ST_RD   = 3'd4,
        ST_HOLD = 3'd5
    } ctl_state_e;

    typedef enum logic [1:0] {
        OP_EXT   = 2'b00,
        OP_WRITE = 2'b01,
        OP_READ  = 2'b10,
        OP_ERASE = 2'b11
    } opcode_e;

    typedef enum logic [1:0] {
        EX_LOCK   = 2'b00,
        EX_FILL   = 2'b01,
        EX_CLEAR  = 2'b10,
        EX_UNLOCK = 2'b11
    } ext_e;

endpackage

// File: rtl/ser_eeprom_sync.sv
module ser_eeprom_sync #(
    parameter int STAGES = 2,
    parameter int W      = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] chain [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    chain[s] <= '0;
                end else if (s == 0) begin
                    chain[s] <= d;
                end else begin
                    chain[s] <= chain[(s == 0) ? 0 : s-1];
                end
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/ser_eeprom_array.sv
module ser_eeprom_array #(
    parameter int WORD_W = 16,
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic              all,
    input  logic [ADDR_W-1:0] addr,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DEPTH-1:0][WORD_W-1:0] store;

    generate
        for (genvar i = 0; i < DEPTH; i++) begin : g_word
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    store[i] <= '1;
                end else if (we && (all || addr == ADDR_W'(i))) begin
                    store[i] <= wdata;
                end
            end
        end
    endgenerate

    assign rdata = store[addr];

    // R8 / R4: contents only move on a write strobe
    a_r8_hold_without_we: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(store));

    // R7: a whole-array program leaves first and last word equal
    a_r7_fill_uniform: assert property (@(posedge clk) disable iff (!rst_n)
        (we && all) |=> (store[0] == store[DEPTH-1]));
endmodule

// File: rtl/ser_eeprom_ctrl.sv
module ser_eeprom_ctrl
    import ser_eeprom_pkg::*;
#(
    parameter int WORD_W = 16,
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_i,
    input  logic              sclk_i,
    input  logic              din_i,
    input  logic [WORD_W-1:0] rd_word,
    output logic [ADDR_W-1:0] addr_o,
    output logic              we_o,
    output logic              all_o,
    output logic [WORD_W-1:0] wdata_o,
    output logic              dout_o
);
    localparam int CNT_W = $clog2(WORD_W + 2);
    localparam logic [CNT_W-1:0] OPC_LAST = CNT_W'(1);
    localparam logic [CNT_W-1:0] ADR_LAST = CNT_W'(ADDR_W - 1);
    localparam logic [CNT_W-1:0] DIN_LAST = CNT_W'(WORD_W - 1);
    localparam logic [CNT_W-1:0] RD_LAST  = CNT_W'(WORD_W);

    ctl_state_e        state_q, state_nx;
    logic [CNT_W-1:0]  cnt_q, cnt_nx;
    logic              sclk_q;
    logic              rise;
    opcode_e           opc_q;
    logic [ADDR_W-1:0] adr_q;
    logic [WORD_W-1:0] dsh_q;
    logic [WORD_W:0]   rsh_q;
    logic              wen_q;

    logic [ADDR_W-1:0] adr_now;
    logic [WORD_W-1:0] dat_now;
    ext_e              ext_now;
    ext_e              ext_q;
    logic              step;
    logic              adr_done;
    logic              din_done;

    assign rise     = sclk_i & ~sclk_q;
    assign step     = rise & cs_i;
    assign adr_now  = {adr_q[ADDR_W-2:0], din_i};
    assign dat_now  = {dsh_q[WORD_W-2:0], din_i};
    assign ext_now  = ext_e'(adr_now[ADDR_W-1 -: 2]);
    assign ext_q    = ext_e'(adr_q[ADDR_W-1 -: 2]);
    assign adr_done = step && (state_q == ST_ADR) && (cnt_q == ADR_LAST);
    assign din_done = step && (state_q == ST_DIN) && (cnt_q == DIN_LAST);

    // next-state logic
    always_comb begin
        state_nx = state_q;
        cnt_nx   = cnt_q;
        unique case (state_q)
            ST_IDLE: begin
                if (rise && din_i) begin
                    state_nx = ST_OPC;
                    cnt_nx   = '0;
                end
            end
            ST_OPC: begin
                if (rise) begin
                    if (cnt_q == OPC_LAST) begin
                        state_nx = ST_ADR;
                        cnt_nx   = '0;
                    end else begin
                        cnt_nx = cnt_q + 1'b1;
                    end
                end
            end
            ST_ADR: begin
                if (rise) begin
                    if (cnt_q == ADR_LAST) begin
                        cnt_nx = '0;
                        unique case (opc_q)
                            OP_READ:  state_nx = ST_RD;
                            OP_WRITE: state_nx = ST_DIN;
                            OP_ERASE: state_nx = ST_HOLD;
                            OP_EXT:   state_nx = (ext_now == EX_FILL) ? ST_DIN : ST_HOLD;
                            default:  state_nx = ST_HOLD;
                        endcase
                    end else begin
                        cnt_nx = cnt_q + 1'b1;
                    end
                end
            end
            ST_DIN: begin
                if (rise) begin
                    if (cnt_q == DIN_LAST) begin
                        state_nx = ST_HOLD;
                        cnt_nx   = '0;
                    end else begin
                        cnt_nx = cnt_q + 1'b1;
                    end
                end
            end
            ST_RD: begin
                if (rise) begin
                    if (cnt_q == RD_LAST) begin
                        state_nx = ST_HOLD;
                        cnt_nx   = '0;
                    end else begin
                        cnt_nx = cnt_q + 1'b1;
                    end
                end
            end
            ST_HOLD: begin
                state_nx = ST_HOLD;
            end
            default: begin
                state_nx = ST_IDLE;
                cnt_nx   = '0;
            end
        endcase
        if (!cs_i) begin
            state_nx = ST_IDLE;
            cnt_nx   = '0;
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            sclk_q  <= 1'b0;
        end else begin
            state_q <= state_nx;
            cnt_q   <= cnt_nx;
            sclk_q  <= sclk_i;
        end
    end

    // datapath registers and write-enable latch
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            opc_q <= OP_EXT;
            adr_q <= '0;
            dsh_q <= '0;
            rsh_q <= '0;
            wen_q <= 1'b0;
        end else if (step) begin
            unique case (state_q)
                ST_OPC: opc_q <= opcode_e'({opc_q[0], din_i});
                ST_ADR: begin
                    adr_q <= adr_now;
                    if (cnt_q == ADR_LAST) begin
                        if (opc_q == OP_READ) begin
                            rsh_q <= {1'b0, rd_word};
                        end
                        if (opc_q == OP_EXT && ext_now == EX_UNLOCK) begin
                            wen_q <= 1'b1;
                        end
                        if (opc_q == OP_EXT && ext_now == EX_LOCK) begin
                            wen_q <= 1'b0;
                        end
                    end
                end
                ST_DIN: dsh_q <= dat_now;
                ST_RD:  rsh_q <= {rsh_q[WORD_W-1:0], 1'b0};
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        addr_o  = (state_q == ST_ADR) ? adr_now : adr_q;
        we_o    = 1'b0;
        all_o   = 1'b0;
        wdata_o = '1;
        if (adr_done && wen_q) begin
            if (opc_q == OP_ERASE) begin
                we_o = 1'b1;
            end else if (opc_q == OP_EXT && ext_now == EX_CLEAR) begin
                we_o  = 1'b1;
                all_o = 1'b1;
            end
        end
        if (din_done && wen_q) begin
            we_o    = 1'b1;
            wdata_o = dat_now;
            all_o   = (opc_q == OP_EXT) && (ext_q == EX_FILL);
        end
        dout_o = (state_q == ST_RD) ? rsh_q[WORD_W] : 1'b0;
    end

    // R2: zero bits in IDLE do not start a command
    a_r2_wait_for_start: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && cs_i && rise && !din_i) |=> (state_q == ST_IDLE));

    // R9: deselect returns to IDLE with output low
    a_r9_abort_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_i |=> (state_q == ST_IDLE && !dout_o));

    // R6: the latch only moves on a selected serial edge
    a_r6_latch_on_edge: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(wen_q) |-> $past(step));

    // R3: read output holds between serial edges
    a_r3_dout_steady: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RD && cs_i && !rise) |=> $stable(dout_o));

    // R12: a finished command stays finished while selected
    a_r12_hold_sticks: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HOLD && cs_i) |=> (state_q == ST_HOLD));
endmodule

// File: rtl/ser_eeprom.sv
module ser_eeprom #(
    parameter int WORD_W      = 16,
    parameter int ADDR_W      = 6,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs,
    input  logic sclk,
    input  logic din,
    output logic dout
);
    logic [2:0]        pins_s;
    logic              cs_s, sclk_s, din_s;
    logic [ADDR_W-1:0] m_addr;
    logic              m_we, m_all;
    logic [WORD_W-1:0] m_wdata, m_rdata;

    ser_eeprom_sync #(.STAGES(SYNC_STAGES), .W(3)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({cs, sclk, din}),
        .q     (pins_s)
    );

    assign cs_s   = pins_s[2];
    assign sclk_s = pins_s[1];
    assign din_s  = pins_s[0];

    ser_eeprom_ctrl #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .cs_i    (cs_s),
        .sclk_i  (sclk_s),
        .din_i   (din_s),
        .rd_word (m_rdata),
        .addr_o  (m_addr),
        .we_o    (m_we),
        .all_o   (m_all),
        .wdata_o (m_wdata),
        .dout_o  (dout)
    );

    ser_eeprom_array #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_array (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (m_we),
        .all   (m_all),
        .addr  (m_addr),
        .wdata (m_wdata),
        .rdata (m_rdata)
    );

    // R9 / R10: output stays low once deselect has passed the synchronizer
    a_r10_quiet_when_deselected: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_s && $past(!cs_s)) |-> !dout);
endmodule

// File: tb/ser_eeprom_bench.sv
module ser_eeprom_bench;
    localparam int HALF = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs = 1'b0;
    logic sclk = 1'b0;
    logic di = 1'b0;
    logic dout;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    logic [15:0] exp_mem [64];
    bit exp_wen;

    always #2 clk = ~clk;

    ser_eeprom u_ser_eeprom (
        .clk   (clk),
        .rst_n (rst_n),
        .cs    (cs),
        .sclk  (sclk),
        .din   (di),
        .dout  (dout)
    );

    task automatic check(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick_half();
        repeat (HALF) @(negedge clk);
    endtask

    task automatic clk_bit(input logic b);
        di = b; sclk = 1'b0; tick_half();
        sclk = 1'b1; tick_half();
    endtask

    task automatic sel();
        sclk = 1'b0; cs = 1'b1; tick_half();
    endtask

    task automatic desel();
        sclk = 1'b0; cs = 1'b0; di = 1'b0; tick_half(); tick_half();
    endtask

    function automatic bit needs_data(input logic [1:0] op, input logic [5:0] a);
        return (op == 2'b01) || (op == 2'b00 && a[5:4] == 2'b01);
    endfunction

    task automatic model_apply(input logic [1:0] op, input logic [5:0] a, input logic [15:0] d);
        case (op)
            2'b01: if (exp_wen) exp_mem[a] = d;
            2'b11: if (exp_wen) exp_mem[a] = 16'hFFFF;
            2'b00: begin
                case (a[5:4])
                    2'b11: exp_wen = 1'b1;
                    2'b00: exp_wen = 1'b0;
                    2'b10: if (exp_wen) for (int i = 0; i < 64; i++) exp_mem[i] = 16'hFFFF;
                    default: if (exp_wen) for (int i = 0; i < 64; i++) exp_mem[i] = d;
                endcase
            end
            default: ;
        endcase
    endtask

    task automatic send_hdr(input logic [1:0] op, input logic [5:0] a);
        clk_bit(1'b1);
        for (int i = 1; i >= 0; i--) clk_bit(op[i]);
        for (int i = 5; i >= 0; i--) clk_bit(a[i]);
    endtask

    task automatic do_cmd(input logic [1:0] op, input logic [5:0] a, input logic [15:0] d,
                          input int lead, input int trail);
        sel();
        for (int i = 0; i < lead; i++) clk_bit(1'b0);
        send_hdr(op, a);
        if (needs_data(op, a)) for (int i = 15; i >= 0; i--) clk_bit(d[i]);
        for (int i = 0; i < trail; i++) clk_bit(1'($urandom % 2));
        desel();
        model_apply(op, a, d);
    endtask

    task automatic read_chk(input logic [5:0] a, input string req);
        logic [15:0] got;
        got = '0;
        sel();
        send_hdr(2'b10, a);
        check(dout == 1'b0, {req, " R3 leading zero"}, {15'd0, dout}, 16'h0);
        for (int i = 15; i >= 0; i--) begin
            sclk = 1'b0; tick_half();
            sclk = 1'b1; tick_half();
            got[i] = dout;
        end
        check(got == exp_mem[a], {req, " R3 read word"}, got, exp_mem[a]);
        sclk = 1'b0; tick_half();
        sclk = 1'b1; tick_half();
        check(dout == 1'b0, "R10 dout low after last bit", {15'd0, dout}, 16'h0);
        desel();
    endtask

    initial begin
        repeat (195000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=%h expected=%h", 16'h0, 16'h1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED));
        for (int i = 0; i < 64; i++) exp_mem[i] = 16'hFFFF;
        exp_wen = 1'b0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // R1: reset state
        check(dout == 1'b0, "R1 dout after reset", {15'd0, dout}, 16'h0);
        // R11: erased contents
        read_chk(6'd5, "R11 reset contents");
        // R1 / R8: latch clear after reset, write ignored
        do_cmd(2'b01, 6'd5, 16'h1234, 0, 0);
        read_chk(6'd5, "R8 R1 write while locked");

        // R6: unlock with don't-care low bits; R2: leading zeros; R4: write
        do_cmd(2'b00, 6'b110101, 16'h0, 0, 0);
        do_cmd(2'b01, 6'd5, 16'hA5C3, 3, 0);
        read_chk(6'd5, "R4 R2 write after leading zeros");
        do_cmd(2'b01, 6'd9, 16'h0F0F, 0, 0);
        read_chk(6'd9, "R4 write word 9");
        // R5: erase
        do_cmd(2'b11, 6'd9, 16'h0, 0, 0);
        read_chk(6'd9, "R5 erase word 9");
        // R7: fill-all and erase-all
        do_cmd(2'b00, 6'b011010, 16'h3C3C, 0, 0);
        read_chk(6'd0, "R7 fill word 0");
        read_chk(6'd63, "R7 fill word 63");
        do_cmd(2'b00, 6'b100111, 16'h0, 0, 0);
        read_chk(6'd17, "R7 erase-all word 17");
        // R6 / R8: lock, then every program ignored
        do_cmd(2'b00, 6'b001011, 16'h0, 0, 0);
        do_cmd(2'b01, 6'd2, 16'h1111, 0, 0);
        read_chk(6'd2, "R8 R6 write after lock");
        do_cmd(2'b00, 6'b010000, 16'h2222, 0, 0);
        read_chk(6'd40, "R8 fill-all after lock");

        // R12: trailing bits ignored
        do_cmd(2'b00, 6'b111111, 16'h0, 0, 0);
        do_cmd(2'b01, 6'd7, 16'hBEEF, 0, 5);
        read_chk(6'd7, "R12 trailing bits after write");
        sel();
        send_hdr(2'b11, 6'd8);
        for (int i = 0; i < 16; i++) clk_bit(1'b0);
        desel();
        model_apply(2'b11, 6'd8, 16'h0);
        read_chk(6'd8, "R12 trailing bits after erase");

        // R9: abort mid-data
        sel();
        send_hdr(2'b01, 6'd4);
        for (int i = 0; i < 8; i++) clk_bit(1'b0);
        desel();
        read_chk(6'd4, "R9 abort mid-write");
        // R9: abort mid-read, dout back to 0
        sel();
        send_hdr(2'b10, 6'd7);
        for (int i = 0; i < 3; i++) clk_bit(1'b0);
        cs = 1'b0; sclk = 1'b0; tick_half();
        check(dout == 1'b0, "R9 dout after read abort", {15'd0, dout}, 16'h0);
        desel();
        // R9: deselect coincides with last data edge
        sel();
        send_hdr(2'b01, 6'd4);
        for (int i = 0; i < 15; i++) clk_bit(1'b0);
        sclk = 1'b0; tick_half();
        di = 1'b0; sclk = 1'b1; cs = 1'b0; tick_half();
        desel();
        read_chk(6'd4, "R9 deselect on last edge");

        // random mix
        for (int n = 0; n < 100; n++) begin
            logic [1:0]  op;
            logic [5:0]  a;
            logic [15:0] d;
            int sel_op;
            sel_op = int'($urandom % 8);
            a = 6'($urandom);
            d = 16'($urandom);
            case (sel_op)
                0, 1, 7: op = 2'b01;
                2: op = 2'b11;
                3: begin op = 2'b00; a[5:4] = 2'b11; end
                4: begin op = 2'b00; a[5:4] = 2'b00; end
                5: begin op = 2'b00; a[5:4] = 2'b10; end
                default: begin op = 2'b00; a[5:4] = 2'b01; end
            endcase
            do_cmd(op, a, d, int'($urandom % 3), int'($urandom % 3));
            read_chk(6'($urandom), "R4 R5 R7 R8 random");
        end
        for (int i = 0; i < 64; i++) read_chk(6'(i), "R3 sweep");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule